// File: doc/BRIEF.md
# UART Channel-Mode Router with Control Register

This block sits between a UART's serial engines and its two byte queues. It holds the control word, the channel-mode selector and a receive-timeout setting. Every cycle it decides where a received line byte or a CPU data-register write may go: into the receive queue, into the transmit queue, both, or nowhere. The choice depends on the channel mode (normal, automatic echo, local loopback, remote loopback) and on the receive and transmit enables.

The control word also produces one-cycle queue-clear pulses and a break request. A CPU read of the data register pops the receive queue only when popping is allowed. A timer counts character-time ticks after each line byte stored in the receive queue. It raises a one-cycle timeout event once four ticks have passed with no new byte stored.

The three byte paths are valid/ready streams. The line input is held off (`rx_ready` low) only when its byte must enter the transmit queue, transmit is enabled, and that queue cannot accept it. In every other case the byte is consumed in the cycle it is offered: it is stored, dropped, or counted as an overrun. Toward the queues, `rxf_valid` and `txf_valid` are raised only in a cycle where the matching ready is high, so each raised valid is one transfer.

Top module: `uart_mode_router`

## Requirements
- R1: After reset, `ctrl_q` reads 0x128, `mode_q` reads 0, and `rx_en`, `tx_en`, `break_req`, `rx_fifo_rst`, `tx_fifo_rst` and `rx_timeout` are all low.
- R2: A control write with bit 0 set gives `rx_fifo_rst` high for exactly the next cycle. Bit 1 does the same for `tx_fifo_rst`. Neither bit is kept in `ctrl_q`.
- R3: `rx_en` is control bit 2 AND NOT bit 3, and `tx_en` is bit 4 AND NOT bit 5, so a set disable bit wins over a set enable bit.
- R4: `break_req` is control bit 7 AND NOT bit 8.
- R5: In mode 0 (normal), an accepted line byte goes to the receive queue when `rx_en` is high. A CPU write goes to the transmit queue when `tx_en` is high.
- R6: In mode 1 (echo), an accepted line byte goes to the receive queue when `rx_en` is high and also to the transmit queue when `tx_en` is high. A CPU write is dropped.
- R7: In mode 2 (local loopback), a CPU write goes to the receive queue when `rx_en` is high. A line byte is accepted and dropped, and the transmit queue is never pushed.
- R8: In mode 3 (remote loopback), an accepted line byte goes only to the transmit queue when `tx_en` is high. A CPU write is dropped.
- R9: `rx_ready` is low exactly when the mode is 1 or 3, `tx_en` is high and `txf_ready` is low.
- R10: A byte routed to an enabled queue whose ready is low is not pushed and raises `overrun` in that same cycle.
- R11: A line byte offered with `rx_break` high is stored as 0x00, whatever the value on `rx_data`.
- R12: `cpu_rd` pops the receive queue (`rxq_pop` high, `cpu_rdata` = `rxq_data`) only when `rx_en` and `rxq_valid` are both high. Otherwise `rxq_pop` is low and `cpu_rdata` is 0.
- R13: After a line byte is stored in the receive queue, the fourth `char_tick` with no further stored line byte raises `rx_timeout` for one cycle, starting in the cycle after that tick. This happens only if the timeout setting is nonzero. A new stored byte restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 9 | Control word write value |
| mode_we | input | 1 | Channel mode write strobe |
| mode_wdata | input | 2 | Channel mode value (0 normal, 1 echo, 2 local, 3 remote) |
| tout_we | input | 1 | Timeout setting write strobe |
| tout_wdata | input | 8 | Timeout setting; zero disables the timeout event |
| ctrl_q | output | 9 | Stored control word |
| mode_q | output | 2 | Stored channel mode |
| rx_valid | input | 1 | Line byte offered by the deserializer |
| rx_ready | output | 1 | Line byte may be taken this cycle |
| rx_data | input | 8 | Line byte |
| rx_break | input | 1 | Offered line byte is a break condition |
| rxf_valid | output | 1 | Push to receive queue |
| rxf_ready | input | 1 | Receive queue has room |
| rxf_data | output | 8 | Byte pushed to receive queue |
| txf_valid | output | 1 | Push to transmit queue |
| txf_ready | input | 1 | Transmit queue has room |
| txf_data | output | 8 | Byte pushed to transmit queue |
| rxq_valid | input | 1 | Receive queue is not empty |
| rxq_data | input | 8 | Head byte of receive queue |
| rxq_pop | output | 1 | Pop receive queue head |
| cpu_wr | input | 1 | CPU write to data register |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU read of data register |
| cpu_rdata | output | 8 | CPU read byte |
| char_tick | input | 1 | One pulse per character time |
| rx_fifo_rst | output | 1 | One-cycle receive queue clear |
| tx_fifo_rst | output | 1 | One-cycle transmit queue clear |
| rx_en | output | 1 | Receive enabled |
| tx_en | output | 1 | Transmit enabled |
| break_req | output | 1 | Request to drive a break on the line |
| overrun | output | 1 | Routed byte lost because its queue was full |
| rx_timeout | output | 1 | One-cycle receive idle timeout event |

## Verification
A wrong stored control or mode value shows up at once, in the same cycle, on the enables, `break_req` and the routing of the next offered byte. So the random phase checks every combinational output, every cycle, against the bench's own register model. A clear pulse that sticks or is missing is visible one cycle after the control write. A miscounting idle timer shows as `rx_timeout` rising one tick too early or too late, or rising although the timeout setting is zero. The directed timeout cases check both sides of the fourth tick.

// File: rtl/uart_rt_pkg.sv
package uart_rt_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;

  localparam int CTRL_W = 9;
  localparam int B_RXCLR = 0;
  localparam int B_TXCLR = 1;
  localparam int B_RXON  = 2;
  localparam int B_RXOFF = 3;
  localparam int B_TXON  = 4;
  localparam int B_TXOFF = 5;
  localparam int B_BRKGO = 7;
  localparam int B_BRKEND = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
  localparam logic [CTRL_W-1:0] CTRL_KEEP  = ~(CTRL_W'(1 << B_RXCLR) | CTRL_W'(1 << B_TXCLR));
endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_rt_pkg::*;
#(
  parameter int TOUT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  input  logic              tout_we,
  input  logic [TOUT_W-1:0] tout_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output chan_mode_e        mode_q,
  output logic              tout_nz,
  output logic              rx_fifo_rst,
  output logic              tx_fifo_rst,
  output logic              rx_en,
  output logic              tx_en,
  output logic              break_req
);
  logic [TOUT_W-1:0] tout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_RESET;
      mode_q      <= CH_NORMAL;
      tout_q      <= '0;
      rx_fifo_rst <= 1'b0;
      tx_fifo_rst <= 1'b0;
    end else begin
      rx_fifo_rst <= ctrl_we & ctrl_wdata[B_RXCLR];
      tx_fifo_rst <= ctrl_we & ctrl_wdata[B_TXCLR];
      if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_KEEP;
      if (mode_we) mode_q <= chan_mode_e'(mode_wdata);
      if (tout_we) tout_q <= tout_wdata;
    end
  end

  assign tout_nz   = |tout_q;
  assign rx_en     = ctrl_q[B_RXON] & ~ctrl_q[B_RXOFF];
  assign tx_en     = ctrl_q[B_TXON] & ~ctrl_q[B_TXOFF];
  assign break_req = ctrl_q[B_BRKGO] & ~ctrl_q[B_BRKEND];

  // R2: a clear request produces a pulse and is not retained
  assert_rxclr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && ctrl_wdata[B_RXCLR] |=> rx_fifo_rst && !ctrl_q[B_RXCLR]);
  assert_txclr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_rst && !ctrl_we |=> !tx_fifo_rst);
  // R4: a break only starts after a control write
  assert_break_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_req) |-> $past(ctrl_we));
endmodule

// File: rtl/uart_byte_router.sv
module uart_byte_router
  import uart_rt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_mode_e        mode,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rxf_valid,
  input  logic              rxf_ready,
  output logic [DATA_W-1:0] rxf_data,
  output logic              txf_valid,
  input  logic              txf_ready,
  output logic [DATA_W-1:0] txf_data,
  input  logic              rxq_valid,
  input  logic [DATA_W-1:0] rxq_data,
  output logic              rxq_pop,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              overrun,
  output logic              line_stored
);
  logic line_to_rx, line_to_tx, cpu_to_rx, cpu_to_tx;
  logic line_take;
  logic [DATA_W-1:0] line_byte;
  logic rx_req, tx_req;

  always_comb begin
    line_to_rx = (mode == CH_NORMAL) || (mode == CH_ECHO);
    line_to_tx = (mode == CH_ECHO)   || (mode == CH_REMOTE);
    cpu_to_rx  = (mode == CH_LOCAL);
    cpu_to_tx  = (mode == CH_NORMAL);

    rx_ready  = !(line_to_tx && tx_en && !txf_ready);
    line_take = rx_valid && rx_ready;
    line_byte = rx_break ? '0 : rx_data;

    if (line_to_rx) begin
      rx_req   = line_take && rx_en;
      rxf_data = line_byte;
    end else begin
      rx_req   = cpu_to_rx && cpu_wr && rx_en;
      rxf_data = cpu_wdata;
    end

    if (line_to_tx) begin
      tx_req   = line_take && tx_en;
      txf_data = line_byte;
    end else begin
      tx_req   = cpu_to_tx && cpu_wr && tx_en;
      txf_data = cpu_wdata;
    end

    rxf_valid   = rx_req && rxf_ready;
    txf_valid   = tx_req && txf_ready;
    overrun     = (rx_req && !rxf_ready) || (tx_req && !txf_ready);
    line_stored = rxf_valid && line_to_rx;

    rxq_pop   = cpu_rd && rx_en && rxq_valid;
    cpu_rdata = rxq_pop ? rxq_data : '0;
  end

  // R7: local loopback never feeds the transmit queue
  assert_local_no_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == CH_LOCAL |-> !txf_valid);
  // R10: an overrun only occurs against a queue that is not ready
  assert_overrun_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !rxf_ready || !txf_ready);
  // R9: the line is only held off by a full transmit queue
  assert_hold_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !txf_ready && tx_en);
  // R12: a pop needs data and receive enabled
  assert_pop_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop |-> rxq_valid && rx_en);
endmodule

// File: rtl/uart_idle_timer.sv
module uart_idle_timer #(
  parameter int TOUT_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic char_tick,
  input  logic enable,
  output logic rx_timeout
);
  localparam int CNT_W = (TOUT_CHARS > 1) ? $clog2(TOUT_CHARS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOUT_CHARS - 1);

  logic             armed;
  logic [CNT_W-1:0] ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      ticks      <= '0;
      rx_timeout <= 1'b0;
    end else begin
      rx_timeout <= 1'b0;
      if (restart) begin
        armed <= 1'b1;
        ticks <= '0;
      end else if (armed && char_tick) begin
        if (ticks == LAST) begin
          armed      <= 1'b0;
          rx_timeout <= enable;
        end else begin
          ticks <= ticks + 1'b1;
        end
      end
    end
  end

  // R13: the event follows a character tick and lasts one cycle
  assert_tout_after_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> $past(char_tick));
  assert_tout_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |=> !rx_timeout);
endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
  import uart_rt_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int TOUT_W     = 8,
  parameter int TOUT_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [8:0]        ctrl_wdata,
  input  logic              mode_we,
  input  logic [1:0]        mode_wdata,
  input  logic              tout_we,
  input  logic [TOUT_W-1:0] tout_wdata,
  output logic [8:0]        ctrl_q,
  output logic [1:0]        mode_q,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rxf_valid,
  input  logic              rxf_ready,
  output logic [DATA_W-1:0] rxf_data,
  output logic              txf_valid,
  input  logic              txf_ready,
  output logic [DATA_W-1:0] txf_data,
  input  logic              rxq_valid,
  input  logic [DATA_W-1:0] rxq_data,
  output logic              rxq_pop,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              char_tick,
  output logic              rx_fifo_rst,
  output logic              tx_fifo_rst,
  output logic              rx_en,
  output logic              tx_en,
  output logic              break_req,
  output logic              overrun,
  output logic              rx_timeout
);
  chan_mode_e mode_s;
  logic       tout_nz;
  logic       line_stored;

  uart_ctrl_regs #(.TOUT_W(TOUT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tout_we(tout_we), .tout_wdata(tout_wdata),
    .ctrl_q(ctrl_q), .mode_q(mode_s), .tout_nz(tout_nz),
    .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
    .rx_en(rx_en), .tx_en(tx_en), .break_req(break_req)
  );

  uart_byte_router #(.DATA_W(DATA_W)) u_route (
    .clk(clk), .rst_n(rst_n), .mode(mode_s),
    .rx_en(rx_en), .tx_en(tx_en),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_break(rx_break),
    .rxf_valid(rxf_valid), .rxf_ready(rxf_ready), .rxf_data(rxf_data),
    .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_data(txf_data),
    .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_pop(rxq_pop),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .overrun(overrun), .line_stored(line_stored)
  );

  uart_idle_timer #(.TOUT_CHARS(TOUT_CHARS)) u_idle (
    .clk(clk), .rst_n(rst_n), .restart(line_stored),
    .char_tick(char_tick), .enable(tout_nz), .rx_timeout(rx_timeout)
  );

  assign mode_q = mode_s;
endmodule

// File: tb/uart_mode_router_bench.sv
module uart_mode_router_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, mode_we = 0, tout_we = 0;
  logic [8:0] ctrl_wdata = '0;
  logic [1:0] mode_wdata = '0;
  logic [7:0] tout_wdata = '0;
  logic [8:0] ctrl_q;
  logic [1:0] mode_q;
  logic rx_valid = 0, rx_break = 0, rxf_ready = 0, txf_ready = 0, rxq_valid = 0;
  logic cpu_wr = 0, cpu_rd = 0, char_tick = 0;
  logic [7:0] rx_data = '0, rxq_data = '0, cpu_wdata = '0;
  logic rx_ready, rxf_valid, txf_valid, rxq_pop;
  logic [7:0] rxf_data, txf_data, cpu_rdata;
  logic rx_fifo_rst, tx_fifo_rst, rx_en, tx_en, break_req, overrun, rx_timeout;

  int checks = 0;
  int errors = 0;
  logic [8:0] m_ctrl;
  logic [1:0] m_mode;

  always #5 clk = ~clk;

  uart_mode_router u_uart_mode_router (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tout_we(tout_we), .tout_wdata(tout_wdata),
    .ctrl_q(ctrl_q), .mode_q(mode_q),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_break(rx_break),
    .rxf_valid(rxf_valid), .rxf_ready(rxf_ready), .rxf_data(rxf_data),
    .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_data(txf_data),
    .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_pop(rxq_pop),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .char_tick(char_tick),
    .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
    .rx_en(rx_en), .tx_en(tx_en), .break_req(break_req),
    .overrun(overrun), .rx_timeout(rx_timeout)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected combinational outputs from the requirements, given model state and inputs
  function automatic logic [31:0] expect_vec(input logic [8:0] c, input logic [1:0] m);
    logic ren, ten, brk, l2r, l2t, c2r, c2t, rdy, take, rq, tq, rv, tv, ov, pop;
    logic [7:0] lb, rd, td, rdat;
    ren = c[2] && !c[3];
    ten = c[4] && !c[5];
    brk = c[7] && !c[8];
    l2r = (m == 2'd0) || (m == 2'd1);
    l2t = (m == 2'd1) || (m == 2'd3);
    c2r = (m == 2'd2);
    c2t = (m == 2'd0);
    rdy = !(l2t && ten && !txf_ready);
    take = rx_valid && rdy;
    lb = rx_break ? 8'h00 : rx_data;
    rq = l2r ? (take && ren) : (c2r && cpu_wr && ren);
    rd = l2r ? lb : cpu_wdata;
    tq = l2t ? (take && ten) : (c2t && cpu_wr && ten);
    td = l2t ? lb : cpu_wdata;
    rv = rq && rxf_ready;
    tv = tq && txf_ready;
    ov = (rq && !rxf_ready) || (tq && !txf_ready);
    pop = cpu_rd && ren && rxq_valid;
    rdat = pop ? rxq_data : 8'h00;
    return {rdy, rv, rv ? rd : 8'h00, tv, tv ? td : 8'h00, ov, pop, rdat, ren, ten, brk};
  endfunction

  function automatic logic [31:0] actual_vec();
    return {rx_ready, rxf_valid, rxf_valid ? rxf_data : 8'h00, txf_valid,
            txf_valid ? txf_data : 8'h00, overrun, rxq_pop, cpu_rdata, rx_en, tx_en, break_req};
  endfunction

  task automatic wr_ctrl(input logic [8:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_mode(input logic [1:0] v);
    @(negedge clk); mode_we = 1; mode_wdata = v;
    @(negedge clk); mode_we = 0;
  endtask
  task automatic wr_tout(input logic [7:0] v);
    @(negedge clk); tout_we = 1; tout_wdata = v;
    @(negedge clk); tout_we = 0;
  endtask
  task automatic line_push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(ctrl_q == 9'h128, "R1 ctrl", 32'(ctrl_q), 32'h128);
    chk({mode_q, rx_en, tx_en, break_req, rx_fifo_rst, tx_fifo_rst, rx_timeout} == '0,
        "R1 outputs", 32'({mode_q, rx_en, tx_en, break_req, rx_fifo_rst, tx_fifo_rst, rx_timeout}), 32'h0);

    // R2 self-clearing queue clears
    wr_ctrl(9'h017); #1;
    chk(rx_fifo_rst && tx_fifo_rst, "R2 pulse", 32'({rx_fifo_rst, tx_fifo_rst}), 32'h3);
    chk(ctrl_q == 9'h014, "R2 bits not kept", 32'(ctrl_q), 32'h014);
    @(negedge clk); #1;
    chk(!rx_fifo_rst && !tx_fifo_rst, "R2 pulse ends", 32'({rx_fifo_rst, tx_fifo_rst}), 32'h0);

    // R3 disable wins
    wr_ctrl(9'h01C); #1;
    chk({rx_en, tx_en} == 2'b01, "R3 rx dis wins", 32'({rx_en, tx_en}), 32'h1);
    wr_ctrl(9'h034); #1;
    chk({rx_en, tx_en} == 2'b10, "R3 tx dis wins", 32'({rx_en, tx_en}), 32'h2);

    // R4 break request
    wr_ctrl(9'h180); #1;
    chk(!break_req, "R4 stop wins", 32'(break_req), 32'h0);
    wr_ctrl(9'h080); #1;
    chk(break_req, "R4 start", 32'(break_req), 32'h1);

    // R11 break byte stored as zero (normal mode, rx enabled)
    wr_ctrl(9'h014);
    @(negedge clk); rxf_ready = 1; rx_valid = 1; rx_break = 1; rx_data = 8'h5A; #1;
    chk(rxf_valid && rxf_data == 8'h00, "R11 break byte", 32'({rxf_valid, rxf_data}), 32'h100);
    // R10 overrun against a full receive queue
    rx_break = 0; rxf_ready = 0; #1;
    chk(overrun && !rxf_valid, "R10 overrun", 32'({overrun, rxf_valid}), 32'h2);
    @(negedge clk); rx_valid = 0; rxf_ready = 1;

    // R9 echo mode holds line when transmit queue full
    wr_mode(2'd1);
    @(negedge clk); txf_ready = 0; rx_valid = 1; #1;
    chk(!rx_ready && !txf_valid && !rxf_valid, "R9 hold", 32'({rx_ready, txf_valid, rxf_valid}), 32'h0);
    @(negedge clk); rx_valid = 0; txf_ready = 1;

    // R12 read with receive disabled returns zero, no pop
    wr_ctrl(9'h01C);
    @(negedge clk); rxq_valid = 1; rxq_data = 8'hA7; cpu_rd = 1; #1;
    chk(!rxq_pop && cpu_rdata == 8'h00, "R12 disabled read", 32'({rxq_pop, cpu_rdata}), 32'h0);
    @(negedge clk); cpu_rd = 0; rxq_valid = 0;

    // R13 idle timeout after four ticks
    wr_ctrl(9'h014); wr_mode(2'd0); wr_tout(8'd5);
    line_push(8'h11);
    tick(); tick(); tick(); #1;
    chk(!rx_timeout, "R13 early", 32'(rx_timeout), 32'h0);
    tick(); #1;
    chk(rx_timeout, "R13 fire", 32'(rx_timeout), 32'h1);
    @(negedge clk); #1;
    chk(!rx_timeout, "R13 one cycle", 32'(rx_timeout), 32'h0);
    // restart on a new stored byte
    line_push(8'h22);
    tick(); tick();
    line_push(8'h33);
    tick(); tick(); tick(); #1;
    chk(!rx_timeout, "R13 restart", 32'(rx_timeout), 32'h0);
    tick(); #1;
    chk(rx_timeout, "R13 restart fire", 32'(rx_timeout), 32'h1);
    // zero setting suppresses the event
    wr_tout(8'd0);
    line_push(8'h44);
    tick(); tick(); tick(); tick(); #1;
    chk(!rx_timeout, "R13 disabled", 32'(rx_timeout), 32'h0);

    // Random routing phase: R5 R6 R7 R8 R9 R10 R11 R12 R3 R4
    m_ctrl = ctrl_q;
    m_mode = mode_q;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ctrl_we    = ($urandom % 10) == 0;
      ctrl_wdata = 9'($urandom);
      mode_we    = ($urandom % 8) == 0;
      mode_wdata = 2'($urandom);
      rx_valid   = 1'($urandom);
      rx_break   = ($urandom % 6) == 0;
      rx_data    = 8'($urandom);
      rxf_ready  = ($urandom % 4) != 0;
      txf_ready  = ($urandom % 4) != 0;
      rxq_valid  = 1'($urandom);
      rxq_data   = 8'($urandom);
      cpu_wr     = 1'($urandom);
      cpu_wdata  = 8'($urandom);
      cpu_rd     = 1'($urandom);
      #1;
      begin
        logic [31:0] e, a;
        e = expect_vec(m_ctrl, m_mode);
        a = actual_vec();
        chk(a == e, $sformatf("R5 R6 R7 R8 routing mode=%0d", m_mode), a, e);
      end
      @(posedge clk);
      if (ctrl_we) m_ctrl = ctrl_wdata & 9'h1FC;
      if (mode_we) m_mode = mode_wdata;
    end
    @(negedge clk);
    ctrl_we = 0; mode_we = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule